// File: doc/BRIEF.md
# Floating-Point Block Transfer Decoder

A purely combinational decoder that looks at a 32-bit coprocessor load/store instruction word and decides how the floating-point register transfer space treats it. The word is placed in one of four classes: a move of 64 bits between two core registers and the floating-point file, a transfer of one floating-point register, a block transfer of a run of consecutive floating-point registers, or an undefined encoding. For a block transfer it also supplies the base core register, the first floating-point register of the run, the number of registers, and the direction, writeback and precision controls.

Every legality rule on the block-transfer register list is applied in the same logic, and the result is one undefined-instruction flag. The rules cover an empty list, a list that runs past the end of the register file, an over-long double list, writeback to the program counter, and a list that reaches the upper double bank on a file that has only 16 double registers. A feature input tells the decoder whether the upper bank exists. The condition field, access permission and the memory transfers themselves are handled elsewhere in the pipeline.

Top module: `fpls_decode`

## Requirements
- R1: `mine_o` is 1 exactly when bits [27:25] are 110 and bits [11:9] are 101; when it is 0 all other outputs carry no meaning.
- R2: With P = bit 24, U = bit 23 and W = bit 21, P=0 U=0 W=0 gives `kind_o` = 0 (core-register move), and P=1 W=0 gives `kind_o` = 1 (single register transfer).
- R3: P equal to U with W=1 gives `kind_o` = 3 (undefined) and `undef_o` = 1.
- R4: P=0 U=1 (either W), and P=1 U=0 W=1, give `kind_o` = 2 (block transfer).
- R5: For a block transfer, `dbl_o` is bit 8 (1 = double, 0 = single), `load_o` is bit 20, `base_o` is bits [19:16], `wback_o` is bit 21 and `decr_o` is bit 24.
- R6: `first_o` is {bits[15:12], bit 22} for single precision and {bit 22, bits[15:12]} for double precision.
- R7: `count_o` is bits [7:0] for single precision and bits [7:1] for double precision, so bit 0 does not change the double count.
- R8: A block transfer with a count of zero sets `undef_o`.
- R9: A block transfer whose first register plus count exceeds 32 sets `undef_o`; a sum of exactly 32 is legal.
- R10: A double block transfer with a count above 16 sets `undef_o`; a count of 16 is legal.
- R11: A block transfer with writeback and base register 15 sets `undef_o`; base 15 without writeback is legal.
- R12: When `has_d32_i` is 0, a double block transfer whose first register plus count exceeds 16 sets `undef_o`, also when the first register is below 16; a sum of exactly 16 is legal.
- R13: `kind_o` values 0 and 1 never set `undef_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word |
| has_d32_i | input | 1 | 1 when the file has 32 double registers |
| mine_o | output | 1 | Word lies in the floating-point transfer space |
| kind_o | output | 2 | Class: 0 move, 1 single, 2 block, 3 undefined |
| undef_o | output | 1 | Undefined-instruction flag |
| base_o | output | 4 | Base core register |
| first_o | output | 5 | First floating-point register of the run |
| count_o | output | 8 | Number of registers transferred |
| load_o | output | 1 | 1 = load, 0 = store |
| wback_o | output | 1 | Base register is written back |
| dbl_o | output | 1 | 1 = double precision |
| decr_o | output | 1 | 1 = decrement-before addressing |

## Verification
Every P/U/W combination is driven so that the move, single, block and undefined classes are each told apart from their neighbours, and words just outside the transfer space show that the space match rejects them. Block transfers are then placed on both sides of each limit: list end at 32 and 33, double count at 16 and 17, list end at 16 and 17 with the upper bank absent, a zero count in both precisions, and base 15 with and without writeback. A double list that starts below 16 and crosses into the upper bank separates a correct bank check from one that only tests the first register, and an odd double immediate shows that bit 0 stays out of the count.

// File: rtl/fpls_pkg.sv
`timescale 1ns/1ps
package fpls_pkg;

    localparam int WORD_W       = 32;
    localparam int GPR_W        = 4;
    localparam int VREG_W       = 5;
    localparam int IMM_W        = 8;
    localparam int REG_SPACE    = 32;   // registers addressable per precision
    localparam int DP_MAX_COUNT = 16;   // longest legal double list
    localparam int LOW_BANK     = 16;   // double registers without the upper bank
    localparam int PC_INDEX     = 15;
    localparam int SPAN_W       = IMM_W + 1;

    localparam logic [2:0] COP_LDST_GRP = 3'b110;
    localparam logic [2:0] FP_COP_GRP   = 3'b101;

    typedef enum logic [1:0] {
        K_MOV64  = 2'd0,
        K_SINGLE = 2'd1,
        K_MULTI  = 2'd2,
        K_UNDEF  = 2'd3
    } fpls_kind_e;

    typedef struct packed {
        logic p;
        logic u;
        logic w;
    } fpls_puw_t;

    typedef struct packed {
        logic              l;
        logic [GPR_W-1:0]  rn;
        logic [3:0]        vd;
        logic              d;
        logic              dbl;
        logic [IMM_W-1:0]  imm;
    } fpls_xfer_t;

    typedef struct packed {
        logic [GPR_W-1:0]  base;
        logic [VREG_W-1:0] first;
        logic [IMM_W-1:0]  count;
        logic              load;
        logic              wback;
        logic              dbl;
        logic              decr;
    } fpls_multi_t;

    function automatic fpls_puw_t get_puw(input logic [WORD_W-1:0] w);
        fpls_puw_t r;
        r.p = w[24];
        r.u = w[23];
        r.w = w[21];
        return r;
    endfunction

    function automatic fpls_xfer_t get_xfer(input logic [WORD_W-1:0] w);
        fpls_xfer_t r;
        r.l   = w[20];
        r.rn  = w[19:16];
        r.vd  = w[15:12];
        r.d   = w[22];
        r.dbl = w[8];
        r.imm = w[7:0];
        return r;
    endfunction

    // Register number: the extra bit is the low bit for singles, the high bit for doubles.
    function automatic logic [VREG_W-1:0] vreg_num(input logic dbl,
                                                   input logic [3:0] vd,
                                                   input logic d);
        return dbl ? {d, vd} : {vd, d};
    endfunction

    function automatic logic [IMM_W-1:0] list_len(input logic dbl,
                                                  input logic [IMM_W-1:0] imm);
        return dbl ? (imm >> 1) : imm;
    endfunction

endpackage

// File: rtl/fpls_space.sv
`timescale 1ns/1ps
module fpls_space
    import fpls_pkg::*;
(
    input  logic [2:0] cop_grp_i,
    input  logic [2:0] fp_grp_i,
    output logic       mine_o
);
    always_comb begin
        mine_o = (cop_grp_i == COP_LDST_GRP) && (fp_grp_i == FP_COP_GRP);
    end
endmodule

// File: rtl/fpls_classify.sv
`timescale 1ns/1ps
module fpls_classify
    import fpls_pkg::*;
(
    input  fpls_puw_t  puw_i,
    output fpls_kind_e kind_o
);
    always_comb begin
        unique case ({puw_i.p, puw_i.u, puw_i.w})
            3'b000:  kind_o = K_MOV64;
            3'b001:  kind_o = K_UNDEF;
            3'b010,
            3'b011:  kind_o = K_MULTI;
            3'b100,
            3'b110:  kind_o = K_SINGLE;
            3'b101:  kind_o = K_MULTI;
            default: kind_o = K_UNDEF;   // P=1 U=1 W=1
        endcase
    end
endmodule

// File: rtl/fpls_fields.sv
`timescale 1ns/1ps
module fpls_fields
    import fpls_pkg::*;
(
    input  fpls_xfer_t  xfer_i,
    input  logic        pre_i,
    input  logic        wb_i,
    output fpls_multi_t multi_o
);
    always_comb begin
        multi_o.base  = xfer_i.rn;
        multi_o.first = vreg_num(xfer_i.dbl, xfer_i.vd, xfer_i.d);
        multi_o.count = list_len(xfer_i.dbl, xfer_i.imm);
        multi_o.load  = xfer_i.l;
        multi_o.wback = wb_i;
        multi_o.dbl   = xfer_i.dbl;
        multi_o.decr  = pre_i;
    end
endmodule

// File: rtl/fpls_legal.sv
`timescale 1ns/1ps
module fpls_legal
    import fpls_pkg::*;
#(
    parameter int SPACE     = REG_SPACE,
    parameter int DP_LIMIT  = DP_MAX_COUNT,
    parameter int BANK_LOW  = LOW_BANK,
    parameter int PC_REG    = PC_INDEX
) (
    input  fpls_multi_t multi_i,
    input  logic        has_d32_i,
    output logic        bad_o
);
    logic [SPAN_W-1:0] span_end;
    logic              empty_list;
    logic              past_space;
    logic              dp_too_long;
    logic              pc_wb;
    logic              upper_bank;

    always_comb begin
        span_end    = SPAN_W'(multi_i.first) + SPAN_W'(multi_i.count);
        empty_list  = (multi_i.count == '0);
        past_space  = (span_end > SPAN_W'(SPACE));
        dp_too_long = multi_i.dbl && (multi_i.count > IMM_W'(DP_LIMIT));
        pc_wb       = multi_i.wback && (multi_i.base == GPR_W'(PC_REG));
        upper_bank  = multi_i.dbl && !has_d32_i && (span_end > SPAN_W'(BANK_LOW));
        bad_o       = empty_list | past_space | dp_too_long | pc_wb | upper_bank;
    end
endmodule

// File: rtl/fpls_decode.sv
`timescale 1ns/1ps
module fpls_decode
    import fpls_pkg::*;
(
    input  logic [31:0] insn_i,
    input  logic        has_d32_i,
    output logic        mine_o,
    output logic [1:0]  kind_o,
    output logic        undef_o,
    output logic [3:0]  base_o,
    output logic [4:0]  first_o,
    output logic [7:0]  count_o,
    output logic        load_o,
    output logic        wback_o,
    output logic        dbl_o,
    output logic        decr_o
);
    fpls_puw_t   puw;
    fpls_xfer_t  xfer;
    fpls_kind_e  kind;
    fpls_multi_t multi;
    logic        list_bad;
    logic        unused_cond;

    assign puw         = get_puw(insn_i);
    assign xfer        = get_xfer(insn_i);
    assign unused_cond = ^insn_i[31:28];

    fpls_space u_space (
        .cop_grp_i (insn_i[27:25]),
        .fp_grp_i  (insn_i[11:9]),
        .mine_o    (mine_o)
    );

    fpls_classify u_class (
        .puw_i  (puw),
        .kind_o (kind)
    );

    fpls_fields u_fields (
        .xfer_i  (xfer),
        .pre_i   (puw.p),
        .wb_i    (puw.w),
        .multi_o (multi)
    );

    fpls_legal u_legal (
        .multi_i   (multi),
        .has_d32_i (has_d32_i),
        .bad_o     (list_bad)
    );

    always_comb begin
        kind_o  = kind;
        undef_o = (kind == K_UNDEF) || ((kind == K_MULTI) && list_bad);
        base_o  = multi.base;
        first_o = multi.first;
        count_o = multi.count;
        load_o  = multi.load;
        wback_o = multi.wback;
        dbl_o   = multi.dbl;
        decr_o  = multi.decr;
    end
endmodule

// File: rtl/fpls_chk.sv
`timescale 1ns/1ps
module fpls_chk (
    input logic       mine_o,
    input logic       has_d32_i,
    input logic [1:0] kind_o,
    input logic       undef_o,
    input logic [3:0] base_o,
    input logic [4:0] first_o,
    input logic [7:0] count_o,
    input logic       wback_o,
    input logic       dbl_o
);
    logic [8:0] span;
    assign span = {4'd0, first_o} + {1'b0, count_o};

    always_comb begin
        if (mine_o === 1'b1) begin
            if (kind_o == 2'd3)
                AST_CLASS_UNDEF: assert (undef_o);                               // R3
            if (kind_o == 2'd0 || kind_o == 2'd1)
                AST_XFER_CLEAN: assert (!undef_o);                               // R13
            if (kind_o == 2'd2 && !undef_o)
                AST_LIST_NONZERO: assert (count_o != 8'd0);                      // R8
            if (kind_o == 2'd2 && !undef_o)
                AST_LIST_IN_SPACE: assert (span <= 9'd32);                       // R9
            if (kind_o == 2'd2 && dbl_o && !undef_o)
                AST_DP_COUNT_LIMIT: assert (count_o <= 8'd16);                   // R10
            if (kind_o == 2'd2 && wback_o && base_o == 4'd15)
                AST_NO_PC_WBACK: assert (undef_o);                               // R11
            if (kind_o == 2'd2 && dbl_o && !has_d32_i && !undef_o)
                AST_LOW_BANK_ONLY: assert (span <= 9'd16);                       // R12
        end
    end
endmodule

bind fpls_decode fpls_chk u_chk (
    .mine_o    (mine_o),
    .has_d32_i (has_d32_i),
    .kind_o    (kind_o),
    .undef_o   (undef_o),
    .base_o    (base_o),
    .first_o   (first_o),
    .count_o   (count_o),
    .wback_o   (wback_o),
    .dbl_o     (dbl_o)
);

// File: tb/sim_fpls_decode.sv
`timescale 1ns/1ps
module sim_fpls_decode;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic [31:0] insn;
    logic        has_d32;
    logic        mine;
    logic [1:0]  kind;
    logic        undef;
    logic [3:0]  base;
    logic [4:0]  first;
    logic [7:0]  count;
    logic        load, wback, dbl, decr;

    fpls_decode u0 (
        .insn_i    (insn),
        .has_d32_i (has_d32),
        .mine_o    (mine),
        .kind_o    (kind),
        .undef_o   (undef),
        .base_o    (base),
        .first_o   (first),
        .count_o   (count),
        .load_o    (load),
        .wback_o   (wback),
        .dbl_o     (dbl),
        .decr_o    (decr)
    );

    typedef struct {
        string req;
        bit    mine;
        int    kind;
        bit    undef;
        int    base, first, count;
        bit    load, wback, dbl, decr;
    } item_t;

    item_t sb[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    function automatic logic [31:0] mk(bit p, bit u, bit w, bit l, int rn,
                                       bit d, int vd, bit dp, int imm);
        return {4'hE, 3'b110, p, u, d, w, l, 4'(rn), 4'(vd), 3'b101, dp, 8'(imm)};
    endfunction

    task automatic go(string req, logic [31:0] w, bit d32, bit exp_mine,
                      int exp_kind, bit exp_undef);
        item_t it;
        @(posedge clk);
        insn    <= w;
        has_d32 <= d32;
        it.req   = req;
        it.mine  = exp_mine;
        it.kind  = exp_kind;
        it.undef = exp_undef;
        it.base  = int'(w[19:16]);
        it.dbl   = w[8];
        it.first = w[8] ? int'({w[22], w[15:12]}) : int'({w[15:12], w[22]});
        it.count = w[8] ? int'(w[7:1]) : int'(w[7:0]);
        it.load  = w[20];
        it.wback = w[21];
        it.decr  = w[24];
        sb.push_back(it);
    endtask

    function automatic bit cmp(string req, string what, int act, int exp);
        if (act != exp) begin
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
            return 1'b1;
        end
        return 1'b0;
    endfunction

    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            item_t e;
            bit    bad;
            e   = sb.pop_front();
            bad = cmp(e.req, "mine", int'(mine), int'(e.mine));
            if (e.mine) begin
                bad |= cmp(e.req, "kind",  int'(kind),  e.kind);
                bad |= cmp(e.req, "undef", int'(undef), int'(e.undef));
                if (e.kind == 2) begin
                    bad |= cmp(e.req, "base",  int'(base),  e.base);
                    bad |= cmp(e.req, "first", int'(first), e.first);
                    bad |= cmp(e.req, "count", int'(count), e.count);
                    bad |= cmp(e.req, "load",  int'(load),  int'(e.load));
                    bad |= cmp(e.req, "wback", int'(wback), int'(e.wback));
                    bad |= cmp(e.req, "dbl",   int'(dbl),   int'(e.dbl));
                    bad |= cmp(e.req, "decr",  int'(decr),  int'(e.decr));
                end
            end
            n_run++;
            if (bad) n_fail++;
        end
    end

    initial begin
        insn    = 32'd0;
        has_d32 = 1'b1;
        repeat (3) @(posedge clk);
        rst <= 1'b0;

        // R1: idle word and near misses are outside the space
        go("R1", 32'd0, 1, 0, 0, 0);
        go("R1", mk(0,1,0,1,2,0,4,0,3) ^ 32'h0200_0000, 1, 0, 0, 0);
        go("R1", mk(0,1,0,1,2,0,4,0,3) ^ 32'h0000_0200, 1, 0, 0, 0);
        // R2 / R13: move and single classes never undefined
        go("R2", mk(0,0,0,1,3,0,1,1,2), 1, 1, 0, 0);
        go("R13", mk(1,0,0,0,15,1,7,0,0), 1, 1, 1, 0);
        go("R2", mk(1,1,0,1,4,0,2,1,0), 1, 1, 1, 0);
        // R3: P equals U with writeback
        go("R3", mk(0,0,1,0,1,0,1,0,2), 1, 1, 3, 1);
        go("R3", mk(1,1,1,1,1,0,1,1,2), 1, 1, 3, 1);
        // R4 / R6 / R7: single block increment, first 9 count 3
        go("R4", mk(0,1,0,0,2,1,4,0,3), 1, 1, 2, 0);
        go("R6", mk(0,1,1,1,5,0,3,0,1), 1, 1, 2, 0);
        // R5 / R6: double decrement-before with writeback, first 18 count 4
        go("R5", mk(1,0,1,1,13,1,2,1,8), 1, 1, 2, 0);
        // R12: same list without the upper bank
        go("R12", mk(1,0,1,1,13,1,2,1,8), 0, 1, 2, 1);
        go("R12", mk(0,1,0,1,0,0,14,1,6), 0, 1, 2, 1);
        go("R12", mk(0,1,0,1,0,0,14,1,4), 0, 1, 2, 0);
        // R8: empty lists
        go("R8", mk(0,1,0,0,1,0,0,0,0), 1, 1, 2, 1);
        go("R8", mk(0,1,0,0,1,0,0,1,1), 1, 1, 2, 1);
        // R9: list end at 32 and 33
        go("R9", mk(0,1,0,0,1,0,15,0,2), 1, 1, 2, 0);
        go("R9", mk(0,1,0,0,1,0,15,0,3), 1, 1, 2, 1);
        go("R9", mk(0,1,0,0,1,1,1,1,32), 1, 1, 2, 1);
        // R10 / R7: double count 17, 16, and odd immediate giving 16
        go("R10", mk(0,1,0,1,2,0,0,1,34), 1, 1, 2, 1);
        go("R10", mk(0,1,0,1,2,0,0,1,32), 1, 1, 2, 0);
        go("R7", mk(0,1,0,1,2,0,0,1,33), 1, 1, 2, 0);
        // R11: base 15
        go("R11", mk(0,1,1,1,15,0,0,0,2), 1, 1, 2, 1);
        go("R11", mk(0,1,0,1,15,0,0,0,2), 1, 1, 2, 0);
        go("R11", mk(1,0,1,0,15,0,0,0,2), 1, 1, 2, 1);

        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule